// File: doc/BRIEF.md
# Leveled Vectored Interrupt Controller

This block gathers interrupt requests from on-chip peripherals and from seven external request pins and tells the processor core which request to serve next. The sources are grouped into seven levels, 1 (lowest) to 7 (highest). Most sources are programmable: software gives each one a level and a 3-bit priority within that level. The remaining seven sources are hard-wired, one per level. Each of them follows the external request pin of its level and sits at a fixed rank in the middle of that level's priority range.

The controller presents a registered pair to the core: the level of the winning request and its vector number. Each source has its own vector. The core fetches the vector through either a hardware acknowledge strobe or a software acknowledge read. Both return the vector the core saw in the acknowledge cycle, and an empty controller answers with a spurious vector. Sources can be masked one at a time or all at once. A wake-up output is formed purely from logic, with no register, so that it can restart a stopped clock.

All control pins are plain strobes and levels. An acknowledge strobe is always answered exactly one cycle later, so the core needs no handshake and there is no back-pressure.

Top module: `lvic_top`

## Requirements
- R1: After reset every source is masked, the mask-all bit is clear, `cur_level` is 0, `cur_vector` is 24 and `wake` is 0, even with every request input high.
- R2: A `cfg_wr` strobe with `cfg_src` below NUM_PROG (49) writes that source's level (`cfg_lvl`), priority (`cfg_pri`) and mask bit (`cfg_msk`, 1 = masked). A programmable source whose level is 0 never competes.
- R3: Sources 49 to 55 are the pin sources. Source 49+k follows `pin_req[k]` at fixed level k+1. Its rank lies above programmable priority 3 and below priority 4. A configuration write to one of these sources changes only its mask bit.
- R4: Among the competing requests the highest level wins. Within a level the higher priority value wins (7 is the highest). If two sources tie, the lower source number wins.
- R5: `cur_level` and `cur_vector` are registered and follow the arbitration of the previous cycle. `cur_vector` is 64 plus the winning source number.
- R6: A source whose mask bit is set does not compete and does not drive `wake`.
- R7: A `glb_wr` strobe loads `glb_mask_all`. While that bit is set no source competes, `cur_level` is 0 and `wake` is 0.
- R8: One cycle after a cycle with `hw_iack` high, `hw_ack_vld` is 1 and `ack_vector` holds the `cur_vector` value of the acknowledge cycle.
- R9: One cycle after a cycle with `sw_iack` high, `sw_ack_vld` is 1 and `ack_vector` holds the `cur_vector` value of the acknowledge cycle.
- R10: An acknowledge while `cur_level` is 0 returns the spurious vector 24, and `cur_vector` is 24 whenever `cur_level` is 0.
- R11: `wake` is a combinational OR of all competing requests. It responds to a request input in the same cycle, before any clock edge.
- R12: A configuration write with `cfg_src` of 56 or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_req | input | NUM_PROG | Requests of the programmable sources 0..NUM_PROG-1 |
| pin_req | input | NUM_LVL | External request pins; bit k belongs to level k+1 |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_src | input | SRC_W | Source number addressed by the write |
| cfg_lvl | input | 3 | Level to write (programmable sources only) |
| cfg_pri | input | 3 | Priority to write (programmable sources only) |
| cfg_msk | input | 1 | Mask bit to write, 1 = masked |
| glb_wr | input | 1 | Write strobe of the mask-all bit |
| glb_mask_all | input | 1 | Value for the mask-all bit |
| hw_iack | input | 1 | Hardware acknowledge strobe |
| sw_iack | input | 1 | Software acknowledge read strobe |
| wake | output | 1 | Combinational wake-up request |
| cur_level | output | 3 | Registered level of the winner, 0 when none |
| cur_vector | output | 8 | Registered vector of the winner, 24 when none |
| ack_vector | output | 8 | Vector returned by the last acknowledge |
| hw_ack_vld | output | 1 | Hardware acknowledge answer valid |
| sw_ack_vld | output | 1 | Software acknowledge answer valid |

## Verification
The hardest case to reach from the ports is the fixed rank of a pin source, which sits between two programmable priority values. The bench holds a pin request and a programmable request at the same level. It then rewrites only the programmable source's priority from 1 to 3 and then to 4, and checks that the winner changes exactly at the step from 3 to 4. It then writes a high level and priority to the pin source itself and checks that the pin source's level and rank stay the same. Ties of equal level and priority are set up the same way, by raising a second source with a higher number to the priority of the current winner.

// File: rtl/lvic_pkg.sv
package lvic_pkg;
  localparam int LVL_W = 3;
  localparam int PRI_W = 3;
  localparam int RANK_W = PRI_W + 1;
  localparam int VEC_W = 8;
  localparam logic [VEC_W-1:0] VEC_BASE = 8'd64;
  localparam logic [VEC_W-1:0] SPUR_VEC = 8'd24;
  // programmable rank is {pri,0}; 7 sits between pri 3 (6) and pri 4 (8)
  localparam logic [RANK_W-1:0] PIN_RANK = 4'd7;
endpackage

// File: rtl/lvic_cfg_bank.sv
module lvic_cfg_bank
  import lvic_pkg::*;
#(
  parameter int NUM_PROG = 49,
  parameter int NUM_LVL  = 7,
  parameter int SRC_W    = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_wr,
  input  logic [SRC_W-1:0]                 cfg_src,
  input  logic [LVL_W-1:0]                 cfg_lvl,
  input  logic [PRI_W-1:0]                 cfg_pri,
  input  logic                             cfg_msk,
  input  logic                             glb_wr,
  input  logic                             glb_mask_all,
  output logic [NUM_PROG-1:0][LVL_W-1:0]   lvl_q,
  output logic [NUM_PROG-1:0][PRI_W-1:0]   pri_q,
  output logic [NUM_PROG+NUM_LVL-1:0]      mask_q,
  output logic                             mask_all_q
);
  localparam int NUM_SRC = NUM_PROG + NUM_LVL;

  for (genvar g = 0; g < NUM_PROG; g++) begin : g_prog
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl_q[g] <= LVL_W'(1);
        pri_q[g] <= '0;
      end else if (cfg_wr && cfg_src == SRC_W'(g)) begin
        lvl_q[g] <= cfg_lvl;
        pri_q[g] <= cfg_pri;
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)
        mask_q[g] <= 1'b1;
      else if (cfg_wr && cfg_src == SRC_W'(g))
        mask_q[g] <= cfg_msk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_all_q <= 1'b0;
    else if (glb_wr)
      mask_all_q <= glb_mask_all;
  end
endmodule

// File: rtl/lvic_arbiter.sv
module lvic_arbiter
  import lvic_pkg::*;
#(
  parameter int NUM_PROG = 49,
  parameter int NUM_LVL  = 7,
  parameter int SRC_W    = 6
) (
  input  logic [NUM_PROG-1:0]              prog_req,
  input  logic [NUM_LVL-1:0]               pin_req,
  input  logic [NUM_PROG-1:0][LVL_W-1:0]   lvl_q,
  input  logic [NUM_PROG-1:0][PRI_W-1:0]   pri_q,
  input  logic [NUM_PROG+NUM_LVL-1:0]      mask_q,
  input  logic                             mask_all_q,
  output logic                             win_valid,
  output logic [LVL_W-1:0]                 win_lvl,
  output logic [SRC_W-1:0]                 win_src,
  output logic                             wake
);
  localparam int NUM_SRC = NUM_PROG + NUM_LVL;
  localparam int KEY_W   = LVL_W + RANK_W;

  logic [NUM_SRC-1:0]            live;
  logic [NUM_SRC-1:0][KEY_W-1:0] key;

  for (genvar g = 0; g < NUM_PROG; g++) begin : g_pkey
    assign live[g] = prog_req[g] & ~mask_q[g] & ~mask_all_q & (lvl_q[g] != '0);
    assign key[g]  = {lvl_q[g], pri_q[g], 1'b0};
  end

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_fkey
    assign live[NUM_PROG+k] = pin_req[k] & ~mask_q[NUM_PROG+k] & ~mask_all_q;
    assign key[NUM_PROG+k]  = {LVL_W'(k + 1), PIN_RANK};
  end

  assign wake = |live;

  logic [KEY_W-1:0] best_key;
  logic [SRC_W-1:0] best_idx;
  logic             found;

  // ascending scan with strict compare keeps the lower number on a tie
  always_comb begin
    best_key = '0;
    best_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (live[i] && (!found || key[i] > best_key)) begin
        best_key = key[i];
        best_idx = SRC_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign win_valid = found;
  assign win_lvl   = best_key[KEY_W-1:RANK_W];
  assign win_src   = best_idx;
endmodule

// File: rtl/lvic_ack_unit.sv
module lvic_ack_unit
  import lvic_pkg::*;
#(
  parameter int SRC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic [SRC_W-1:0] win_src,
  input  logic             hw_iack,
  input  logic             sw_iack,
  output logic [LVL_W-1:0] cur_level,
  output logic [VEC_W-1:0] cur_vector,
  output logic [VEC_W-1:0] ack_vector,
  output logic             hw_ack_vld,
  output logic             sw_ack_vld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_level  <= '0;
      cur_vector <= SPUR_VEC;
    end else if (win_valid) begin
      cur_level  <= win_lvl;
      cur_vector <= VEC_BASE + VEC_W'(win_src);
    end else begin
      cur_level  <= '0;
      cur_vector <= SPUR_VEC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_vector <= SPUR_VEC;
      hw_ack_vld <= 1'b0;
      sw_ack_vld <= 1'b0;
    end else begin
      hw_ack_vld <= hw_iack;
      sw_ack_vld <= sw_iack;
      if (hw_iack || sw_iack)
        ack_vector <= cur_vector;
    end
  end
endmodule

// File: rtl/lvic_top.sv
module lvic_top
  import lvic_pkg::*;
#(
  parameter int NUM_PROG = 49,
  parameter int NUM_LVL  = 7,
  localparam int NUM_SRC = NUM_PROG + NUM_LVL,
  localparam int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PROG-1:0] prog_req,
  input  logic [NUM_LVL-1:0]  pin_req,
  input  logic                cfg_wr,
  input  logic [SRC_W-1:0]    cfg_src,
  input  logic [2:0]          cfg_lvl,
  input  logic [2:0]          cfg_pri,
  input  logic                cfg_msk,
  input  logic                glb_wr,
  input  logic                glb_mask_all,
  input  logic                hw_iack,
  input  logic                sw_iack,
  output logic                wake,
  output logic [2:0]          cur_level,
  output logic [7:0]          cur_vector,
  output logic [7:0]          ack_vector,
  output logic                hw_ack_vld,
  output logic                sw_ack_vld
);
  logic [NUM_PROG-1:0][LVL_W-1:0] lvl_q;
  logic [NUM_PROG-1:0][PRI_W-1:0] pri_q;
  logic [NUM_SRC-1:0]             mask_q;
  logic                           mask_all_q;
  logic                           win_valid;
  logic [LVL_W-1:0]               win_lvl;
  logic [SRC_W-1:0]               win_src;

  lvic_cfg_bank #(.NUM_PROG(NUM_PROG), .NUM_LVL(NUM_LVL), .SRC_W(SRC_W)) u_cfg (
    .clk, .rst_n, .cfg_wr, .cfg_src, .cfg_lvl, .cfg_pri, .cfg_msk,
    .glb_wr, .glb_mask_all, .lvl_q, .pri_q, .mask_q, .mask_all_q
  );

  lvic_arbiter #(.NUM_PROG(NUM_PROG), .NUM_LVL(NUM_LVL), .SRC_W(SRC_W)) u_arb (
    .prog_req, .pin_req, .lvl_q, .pri_q, .mask_q, .mask_all_q,
    .win_valid, .win_lvl, .win_src, .wake
  );

  lvic_ack_unit #(.SRC_W(SRC_W)) u_ack (
    .clk, .rst_n, .win_valid, .win_lvl, .win_src, .hw_iack, .sw_iack,
    .cur_level, .cur_vector, .ack_vector, .hw_ack_vld, .sw_ack_vld
  );
endmodule

// File: rtl/lvic_checker.sv
module lvic_checker #(
  parameter int NUM_PROG = 49,
  parameter int NUM_LVL  = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       glb_wr,
  input logic       glb_mask_all,
  input logic       hw_iack,
  input logic       sw_iack,
  input logic       wake,
  input logic [2:0] cur_level,
  input logic [7:0] cur_vector,
  input logic [7:0] ack_vector,
  input logic       hw_ack_vld,
  input logic       sw_ack_vld
);
  localparam int NUM_SRC = NUM_PROG + NUM_LVL;

  assert_spur_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level == 3'd0 |-> cur_vector == 8'd24);

  assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level != 3'd0 |-> (int'(cur_vector) >= 64 && int'(cur_vector) < 64 + NUM_SRC));

  assert_pin_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level != 3'd0 && int'(cur_vector) >= 64 + NUM_PROG)
      |-> int'(cur_level) == int'(cur_vector) - 64 - NUM_PROG + 1);

  assert_mask_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_wr && glb_mask_all) |=> ##1 (cur_level == 3'd0));

  assert_hw_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_iack |=> (hw_ack_vld && ack_vector == $past(cur_vector)));

  assert_sw_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_iack |=> (sw_ack_vld && ack_vector == $past(cur_vector)));

  assert_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level != 3'd0 |-> $past(wake));
endmodule

bind lvic_top lvic_checker #(.NUM_PROG(NUM_PROG), .NUM_LVL(NUM_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_wr(glb_wr), .glb_mask_all(glb_mask_all),
  .hw_iack(hw_iack), .sw_iack(sw_iack), .wake(wake), .cur_level(cur_level),
  .cur_vector(cur_vector), .ack_vector(ack_vector), .hw_ack_vld(hw_ack_vld),
  .sw_ack_vld(sw_ack_vld)
);

// File: tb/lvic_top_bench.sv
module lvic_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 49;
  localparam int NL = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] prog_req;
  logic [NL-1:0] pin_req;
  logic          cfg_wr;
  logic [5:0]    cfg_src;
  logic [2:0]    cfg_lvl, cfg_pri;
  logic          cfg_msk, glb_wr, glb_mask_all, hw_iack, sw_iack;
  logic          wake, hw_ack_vld, sw_ack_vld;
  logic [2:0]    cur_level;
  logic [7:0]    cur_vector, ack_vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvic_top u_lvic_top (
    .clk, .rst_n, .prog_req, .pin_req, .cfg_wr, .cfg_src, .cfg_lvl, .cfg_pri,
    .cfg_msk, .glb_wr, .glb_mask_all, .hw_iack, .sw_iack, .wake, .cur_level,
    .cur_vector, .ack_vector, .hw_ack_vld, .sw_ack_vld
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // write, then let the registered outputs follow
  task automatic cfg(input int src, input int lvl, input int pri, input bit msk);
    cfg_wr = 1'b1; cfg_src = 6'(src); cfg_lvl = 3'(lvl); cfg_pri = 3'(pri); cfg_msk = msk;
    step();
    cfg_wr = 1'b0;
    step();
  endtask

  task automatic set_mask_all(input bit v);
    glb_wr = 1'b1; glb_mask_all = v;
    step();
    glb_wr = 1'b0;
    step();
  endtask

  task automatic expect_win(input string req, input int lvl, input int vec);
    chk(req, int'(cur_level), lvl);
    chk(req, int'(cur_vector), vec);
  endtask

  task automatic t_reset();
    prog_req = '1; pin_req = '1;
    step();
    expect_win("R1", 0, 24);
    chk("R1 wake", int'(wake), 0);
    chk("R1 ack", int'(hw_ack_vld | sw_ack_vld), 0);
    prog_req = '0; pin_req = '0;
    step();
  endtask

  task automatic t_single();
    cfg(10, 3, 2, 0);
    prog_req[10] = 1'b1;
    #1 chk("R11 wake same cycle", int'(wake), 1);
    step();
    expect_win("R2/R5 single", 3, 74);
  endtask

  task automatic t_order();
    cfg(20, 5, 1, 0);
    prog_req[20] = 1'b1;
    step();
    expect_win("R4 level", 5, 84);
    cfg(5, 5, 6, 0);
    prog_req[5] = 1'b1;
    step();
    expect_win("R4 priority", 5, 69);
    cfg(30, 5, 6, 0);
    prog_req[30] = 1'b1;
    step();
    expect_win("R4 tie", 5, 69);
    prog_req[5] = 1'b0;
    step();
    expect_win("R4 tie released", 5, 94);
    prog_req[30] = 1'b0;
    prog_req[20] = 1'b0;
    step();
    expect_win("R4 fallback", 3, 74);
  endtask

  task automatic t_pin();
    cfg(53, 0, 0, 0);
    pin_req[4] = 1'b1;
    step();
    expect_win("R3 pin", 5, 117);
    prog_req[20] = 1'b1;
    cfg(20, 5, 1, 0);
    expect_win("R3 over pri1", 5, 117);
    cfg(20, 5, 3, 0);
    expect_win("R3 over pri3", 5, 117);
    cfg(20, 5, 4, 0);
    expect_win("R3 under pri4", 5, 84);
    cfg(53, 7, 7, 0);
    expect_win("R3 pin cfg ignored", 5, 84);
    prog_req[20] = 1'b0;
    step();
    expect_win("R3 pin level fixed", 5, 117);
  endtask

  task automatic t_mask();
    cfg(53, 0, 0, 1);
    expect_win("R6 pin masked", 3, 74);
    cfg(10, 3, 2, 1);
    expect_win("R6 all masked", 0, 24);
    chk("R6 wake", int'(wake), 0);
    cfg(10, 3, 2, 0);
    expect_win("R6 unmask", 3, 74);
  endtask

  task automatic t_mask_all();
    set_mask_all(1'b1);
    expect_win("R7 mask all", 0, 24);
    chk("R7 wake", int'(wake), 0);
    set_mask_all(1'b0);
    expect_win("R7 release", 3, 74);
  endtask

  task automatic t_ack();
    hw_iack = 1'b1;
    step();
    hw_iack = 1'b0;
    chk("R8 hw valid", int'(hw_ack_vld), 1);
    chk("R8 hw vector", int'(ack_vector), 74);
    step();
    chk("R8 hw pulse", int'(hw_ack_vld), 0);
    sw_iack = 1'b1;
    step();
    sw_iack = 1'b0;
    chk("R9 sw valid", int'(sw_ack_vld), 1);
    chk("R9 sw vector", int'(ack_vector), 74);
    prog_req[10] = 1'b0;
    step();
    sw_iack = 1'b1;
    step();
    sw_iack = 1'b0;
    chk("R10 sw spurious", int'(ack_vector), 24);
    hw_iack = 1'b1;
    step();
    hw_iack = 1'b0;
    chk("R10 hw valid", int'(hw_ack_vld), 1);
    chk("R10 hw spurious", int'(ack_vector), 24);
  endtask

  task automatic t_level0_oob();
    cfg(40, 0, 7, 0);
    prog_req[40] = 1'b1;
    step();
    expect_win("R2 level zero", 0, 24);
    cfg(40, 2, 0, 0);
    expect_win("R2 level two", 2, 104);
    cfg(60, 7, 7, 0);
    cfg(56, 7, 7, 1);
    expect_win("R12 out of range", 2, 104);
  endtask

  initial begin
    rst_n = 1'b0; prog_req = '0; pin_req = '0; cfg_wr = 1'b0; cfg_src = '0;
    cfg_lvl = '0; cfg_pri = '0; cfg_msk = 1'b0; glb_wr = 1'b0; glb_mask_all = 1'b0;
    hw_iack = 1'b0; sw_iack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_order();
    t_pin();
    t_mask();
    t_mask_all();
    t_ack();
    t_level0_oob();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule